// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host issue single-beat reads and writes to an asynchronous 128K x 8 static RAM. The host raises a request with a write flag, a 17-bit address and write data while the controller reports it is ready. The controller then steps the RAM's select, output-enable and write-enable strobes through a fixed sequence. When the transfer ends it returns a one-cycle done pulse, and read data with it for reads.

Three wait-state parameters set how many clock cycles the read access, the write pulse and the post-write turnaround take. The same RTL can therefore meet slower or faster RAM speed grades. The address is never changed while a write is armed. Output enable stays inactive for the whole write, and the controller releases its data drivers before the RAM can drive the bus again. When no transfer is running, both chip selects sit in their standby levels.

The bidirectional data bus is brought out as three signals: an output value, an output enable and an input value. The pad ring or the bench combines them into the real tristate pin.

Top module: `sram_ctrl`

## Requirements
- R1: While idle, and from reset, the controller holds the active-low select high, the active-high select low, output enable high, write enable high and its data drivers off. It also signals ready.
- R2: A request is accepted only on a clock edge where both the request input and ready are high. While a transfer runs, ready is low and any request is ignored: its address and data never reach the RAM.
- R3: A read keeps the RAM selected, write enable high and output enable low for exactly RD_WAIT+1 cycles. The data bus is sampled at the end of the last of these cycles.
- R4: A write has one setup cycle with the data driven and write enable high. Then write enable is low for exactly WR_WAIT cycles, and output enable stays high throughout.
- R5: The RAM address and the driven write data do not change on any cycle where write enable is low.
- R6: The controller's data drivers are never on while output enable is low.
- R7: Every accepted request produces exactly one done pulse, one cycle wide. For reads, the captured data is presented on the read-data output while done is high and is held after it.
- R8: After a write, at least one cycle with the data drivers off passes before output enable can go low.
- R9: A read's done pulse appears RD_WAIT+1 cycles after acceptance. A write's done pulse appears WR_WAIT+TA_WAIT+1 cycles after acceptance. The next request may be accepted in the same cycle as done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Host address |
| req_wdata_i | input | 8 | Host write data |
| req_ready_o | output | 1 | Controller idle, request may be accepted |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read data |
| ram_addr_o | output | 17 | RAM address |
| ram_cs_n_o | output | 1 | RAM select, active low |
| ram_cs_o | output | 1 | RAM select, active high |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_we_n_o | output | 1 | RAM write enable, active low |
| ram_dq_o | output | 8 | Data driven toward the RAM |
| ram_dq_oe_o | output | 1 | Enable for the data drivers |
| ram_dq_i | input | 8 | Data read from the RAM bus |

## Verification
The assertions assume that the host holds its request fields stable on the edge where the request is accepted. They also assume the RAM model returns settled data within RD_WAIT+1 cycles of the strobes going active. The bench samples all outputs on the falling edge and changes inputs only there. It models the RAM at that edge: stored data is driven only while the part is selected with output enable low and write enable high, and a write is committed while write enable is low. The one deliberate breach of the handshake is a request pulsed while the controller is busy. That pulse checks that such a request is dropped.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_CAPTURE = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5
  } sram_state_e;

  typedef struct packed {
    logic cs_n;
    logic cs;
    logic oe_n;
    logic we_n;
    logic dq_oe;
    logic ready;
  } sram_ctrl_t;

  function automatic sram_ctrl_t strobe_decode(sram_state_e st);
    sram_ctrl_t c;
    c = '{cs_n: 1'b0, cs: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ready: 1'b0};
    unique case (st)
      ST_IDLE:       c = '{cs_n: 1'b1, cs: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ready: 1'b1};
      ST_RD_ACCESS,
      ST_RD_CAPTURE: c.oe_n = 1'b0;
      ST_WR_SETUP:   c.dq_oe = 1'b1;
      ST_WR_PULSE:   begin c.we_n = 1'b0; c.dq_oe = 1'b1; end
      ST_WR_RECOVER: ;
      default:       c = '{cs_n: 1'b1, cs: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ready: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_WAIT = 2,
  parameter int unsigned WR_WAIT = 2,
  parameter int unsigned TA_WAIT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  output logic load_o,
  output logic capture_o,
  output logic done_o,
  output sram_ctrl_t ctrl_o
);

  localparam int unsigned MAX_WAIT = (RD_WAIT > WR_WAIT)
                                     ? ((RD_WAIT > TA_WAIT) ? RD_WAIT : TA_WAIT)
                                     : ((WR_WAIT > TA_WAIT) ? WR_WAIT : TA_WAIT);
  localparam int unsigned CW = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;

  sram_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  sram_ctrl_t ctrl_q;

  assign load_o    = (state_q == ST_IDLE) && req_valid_i;
  assign capture_o = (state_q == ST_RD_CAPTURE);

  always_comb begin
    state_d = state_q;
    cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (req_we_i) begin
          state_d = ST_WR_SETUP;
          cnt_d   = '0;
        end else begin
          state_d = ST_RD_ACCESS;
          cnt_d   = CW'(RD_WAIT - 1);
        end
      end
      ST_RD_ACCESS:  if (cnt_q == '0) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_WR_SETUP: begin
        state_d = ST_WR_PULSE;
        cnt_d   = CW'(WR_WAIT - 1);
      end
      ST_WR_PULSE: if (cnt_q == '0) begin
        state_d = ST_WR_RECOVER;
        cnt_d   = CW'(TA_WAIT - 1);
      end
      ST_WR_RECOVER: if (cnt_q == '0) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: glitch-free and aligned with state_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ctrl_q  <= strobe_decode(ST_IDLE);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      ctrl_q  <= strobe_decode(state_d);
    end
  end

  assign done_o = done_q;
  assign ctrl_o = ctrl_q;

  p_idle_standby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.ready |-> (ctrl_q.cs_n && !ctrl_q.cs && ctrl_q.oe_n && ctrl_q.we_n && !ctrl_q.dq_oe));

  p_accept_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !ctrl_q.ready);

  p_we_oe_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.we_n |-> (ctrl_q.oe_n && ctrl_q.dq_oe));

  p_we_after_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.we_n) |-> $past(ctrl_q.dq_oe));

  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.dq_oe |-> ctrl_q.oe_n);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_done_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ctrl_q.ready);

  p_turnaround_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.oe_n) |-> !$past(ctrl_q.dq_oe));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_q));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RD_WAIT = 2,
  parameter int unsigned WR_WAIT = 2,
  parameter int unsigned TA_WAIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_cs_n_o,
  output logic              ram_cs_o,
  output logic              ram_oe_n_o,
  output logic              ram_we_n_o,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);

  if (RD_WAIT < 1) begin : g_bad_rd_wait
    $error("RD_WAIT must be at least 1");
  end
  if (WR_WAIT < 1) begin : g_bad_wr_wait
    $error("WR_WAIT must be at least 1");
  end
  if (TA_WAIT < 1) begin : g_bad_ta_wait
    $error("TA_WAIT must be at least 1");
  end

  logic       load, capture;
  sram_ctrl_t ctrl;

  sram_ctrl_fsm #(
    .RD_WAIT(RD_WAIT),
    .WR_WAIT(WR_WAIT),
    .TA_WAIT(TA_WAIT)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .load_o     (load),
    .capture_o  (capture),
    .done_o     (done_o),
    .ctrl_o     (ctrl)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .capture_i(capture),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .dq_i     (ram_dq_i),
    .addr_o   (ram_addr_o),
    .wdata_o  (ram_dq_o),
    .rdata_o  (rdata_o)
  );

  assign req_ready_o = ctrl.ready;
  assign ram_cs_n_o  = ctrl.cs_n;
  assign ram_cs_o    = ctrl.cs;
  assign ram_oe_n_o  = ctrl.oe_n;
  assign ram_we_n_o  = ctrl.we_n;
  assign ram_dq_oe_o = ctrl.dq_oe;

  p_addr_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_n_o |-> ($stable(ram_addr_o) && $stable(ram_dq_o)));

  p_busy_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !$past(req_ready_o)) |-> $stable(ram_addr_o));

endmodule

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;

  localparam int unsigned AW = 17;
  localparam int unsigned DW = 8;
  localparam int unsigned RD = 2;
  localparam int unsigned WR = 2;
  localparam int unsigned TA = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready, done, cs_n, cs, oe_n, we_n, dq_oe;
  logic [DW-1:0] rdata, dq_out, dq_in;
  logic [AW-1:0] ram_addr;

  always #10 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RD), .WR_WAIT(WR), .TA_WAIT(TA)) i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(ready), .done_o(done), .rdata_o(rdata),
    .ram_addr_o(ram_addr), .ram_cs_n_o(cs_n), .ram_cs_o(cs), .ram_oe_n_o(oe_n), .ram_we_n_o(we_n),
    .ram_dq_o(dq_out), .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_in)
  );

  int tests = 0, fails = 0, cyc = 0, dones = 0, accepts = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // RAM model and expectation shadow
  logic [DW-1:0] mem    [int unsigned];
  logic [DW-1:0] shadow [int unsigned];

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : '0;
  endfunction
  function automatic logic [DW-1:0] shd_rd(input logic [AW-1:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
  endfunction

  initial dq_in = 8'hEE;
  always @(negedge clk) begin
    if (!cs_n && cs && !we_n && dq_oe) mem[int'(ram_addr)] = dq_out;
    dq_in = (!cs_n && cs && !oe_n && we_n) ? mem_rd(ram_addr) : 8'hEE;
  end

  // scoreboard
  typedef struct {
    bit            we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            acc;
  } item_t;
  item_t exp_q[$];

  task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    it.we = we; it.addr = a; it.acc = cyc;
    if (we) begin
      shadow[int'(a)] = d;
      it.data = d;
    end else begin
      it.data = shd_rd(a);
    end
    exp_q.push_back(it);
    accepts++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  int we_run = 0, oe_run = 0;
  logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dq = '0;
  always @(negedge clk) if (rst_n) begin
    if (done) begin
      item_t it;
      dones++;
      if (exp_q.size() == 0) chk(1'b0, "R7 spurious done", 1, 0);
      else begin
        it = exp_q.pop_front();
        if (it.we) chk(cyc - it.acc == int'(WR + TA + 1), "R9 write latency", cyc - it.acc, WR + TA + 1);
        else begin
          chk(cyc - it.acc == int'(RD + 1), "R9 read latency", cyc - it.acc, RD + 1);
          chk(rdata == it.data, "R3 read data", rdata, it.data);
        end
      end
    end
    if (ready) chk(cs_n && !cs && oe_n && we_n && !dq_oe, "R1 idle standby",
                   {cs_n, cs, oe_n, we_n, dq_oe}, 5'b10110);
    if (dq_oe) chk(oe_n, "R6 drivers vs output enable", oe_n, 1);
    if (!we_n) begin
      we_run++;
      chk(oe_n && dq_oe, "R4 oe high and data driven in pulse", {oe_n, dq_oe}, 2'b11);
      if (!prev_we_n) chk(ram_addr == prev_addr && dq_out == prev_dq, "R5 address/data stable",
                          {ram_addr, dq_out}, {prev_addr, prev_dq});
      else chk(prev_dq_oe, "R4 setup cycle before pulse", prev_dq_oe, 1);
    end else if (!prev_we_n) begin
      chk(we_run == int'(WR), "R4 write pulse width", we_run, WR);
      we_run = 0;
    end
    if (!oe_n) begin
      oe_run++;
      if (prev_oe_n) chk(!prev_dq_oe, "R8 turnaround before read", prev_dq_oe, 0);
    end else if (!prev_oe_n) begin
      chk(oe_run == int'(RD + 1), "R3 read strobe width", oe_run, RD + 1);
      oe_run = 0;
    end
    prev_we_n = we_n; prev_oe_n = oe_n; prev_dq_oe = dq_oe; prev_addr = ram_addr; prev_dq = dq_out;
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready && !done && cs_n && !cs && oe_n && we_n && !dq_oe, "R1 reset state",
        {ready, done, cs_n, cs, oe_n, we_n, dq_oe}, 7'b1010110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_req(1'b1, 17'h00000, 8'h5A);   // lowest address
    do_req(1'b1, 17'h1FFFF, 8'hFF);   // highest address
    do_req(1'b1, 17'h0ABCD, 8'h00);
    do_req(1'b0, 17'h00000, 8'h00);
    do_req(1'b0, 17'h1FFFF, 8'h00);
    do_req(1'b0, 17'h0ABCD, 8'h00);
    do_req(1'b0, 17'h12345, 8'h00);   // never written
    // write then immediate read of the same location (R8 turnaround)
    do_req(1'b1, 17'h0ABCD, 8'hC3);
    do_req(1'b0, 17'h0ABCD, 8'h00);
    // R2: request pulsed while busy must be dropped
    do_req(1'b1, 17'h00042, 8'h11);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h00077; req_wdata = 8'h99;
    chk(!ready, "R2 busy while pulsing", ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    do_req(1'b0, 17'h00077, 8'h00);
    do_req(1'b0, 17'h00042, 8'h00);
    // alternating patterns
    for (int i = 0; i < 6; i++) do_req(1'b1, AW'(17'h10000 + i * 3), DW'(8'h81 ^ (i * 37)));
    for (int i = 0; i < 6; i++) do_req(1'b0, AW'(17'h10000 + i * 3), 8'h00);

    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all requests completed", exp_q.size(), 0);
    chk(dones == accepts, "R7 one done per request", dones, accepts);
    chk(!mem.exists(32'h77), "R2 ignored write absent from RAM", mem.exists(32'h77), 0);
    finish_run();
  end

endmodule